// File: doc/BRIEF.md
# Seconds Real-Time Clock with Alarm

This block is a register-mapped real-time clock. A prescaler divides the slow input clock down to one tick per second, and each tick advances a 32-bit count of elapsed seconds. Software can set that count at any time. An alarm register holds a target seconds value. When the count steps onto that value with the alarm armed, a sticky pending flag is raised. A separate sticky flag records every one-second step. The interrupt line stays high while a flag that is allowed to drive it is set. A scratch register keeps any word written to it, so boot code can leave a marker such as 0x12345678 to tell whether the clock was already set up.

Access is through a plain register port with an address, write data, a write strobe and combinational read data. Every accepted write opens a commit window of a fixed number of clock cycles. During that window a ready bit in the control register reads 0, and further writes are dropped. The two event flags clear only when 0 is written to them, so a read-modify-write of the control register never loses an event that has just arrived. Software reads the seconds register twice in a row and uses the value once two reads agree.

Top module: `rtc_seconds_alarm`

## Requirements
- R1: After synchronous reset, the seconds, alarm and scratch registers read 0. The control register reads 0x8, which is write-ready set with every other bit clear, and `irq` is low.
- R2: Each TICK_DIV clock cycles after reset the seconds count increases by exactly one and the tick flag (control bit 2) is set. The count holds between steps.
- R3: An accepted write drives write-ready (control bit 3) to 0 for COMMIT_CYC cycles, after which it returns to 1. Any write presented while write-ready is 0 changes no register.
- R4: When a step makes the count equal to the alarm register while alarm-enable (control bit 0) is 1, the alarm-pending flag (control bit 1) is set. With alarm-enable at 0 the flag is not set.
- R5: A control write with 0 in bit 1 or bit 2 clears that flag. A 1 in that bit leaves the flag as it was. An event in the same cycle as the write still sets the flag.
- R6: `irq` is high exactly when alarm-pending is set, or when the tick flag is set together with tick-interrupt-enable (control bit 4).
- R7: The scratch register returns the last word accepted into it.
- R8: The register offsets are 0x0 for seconds, 0x4 for alarm, 0x8 for control and 0xC for scratch. Every other offset reads as zero.
- R9: Two reads of the seconds register in consecutive cycles that return the same value return the true count.
- R10: A write to the seconds register in the same cycle as a step stores the written value. In that case no step takes place and the tick flag is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock that drives the prescaler and all registers |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_rdata | output | DATA_W | Read data for the current offset, combinational |
| irq | output | 1 | Level interrupt |

## Verification
Read data is combinational from the registers. A value written at a rising edge is therefore visible on `bus_rdata` in the very next cycle. Write-ready falls in that same cycle and stays low for COMMIT_CYC cycles. A step lands on the edge that closes the TICK_DIV-th cycle of each period, and the flags and `irq` follow on that same edge. The bench drives inputs just after a falling edge and compares `bus_rdata` and `irq` with a behavioural model before the next rising edge. The model then advances on that rising edge, so every result is compared in the cycle it is due, including writes that land on a step and writes dropped during the commit window.

// File: rtl/rtc_sec_pkg.sv
package rtc_sec_pkg;
   // register offsets (bytes)
   localparam int OFS_SECS    = 0;
   localparam int OFS_ALARM   = 4;
   localparam int OFS_CTRL    = 8;
   localparam int OFS_SCRATCH = 12;
   // control register bit positions
   localparam int CB_AEN   = 0;
   localparam int CB_APEND = 1;
   localparam int CB_TFLAG = 2;
   localparam int CB_WRDY  = 3;
   localparam int CB_TIE   = 4;
   localparam int CB_COUNT = 5;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_SECS,
      SEL_ALARM,
      SEL_CTRL,
      SEL_SCRATCH
   } reg_sel_e;
endpackage

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen #(
   parameter int DIV = 32768
) (
   input  logic clk,
   input  logic rst,
   output logic tick
);
   localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
   localparam bit IS_POW2 = ((DIV & (DIV - 1)) == 0);

   if (DIV < 2) begin : g_bad_div
      $error("rtc_tick_gen: DIV must be at least 2");
   end

   logic [CW-1:0] cnt;

   if (IS_POW2) begin : g_pow2
      // natural wrap, terminal count is all ones
      always_ff @(posedge clk) begin
         if (rst) cnt <= '0;
         else     cnt <= cnt + CW'(1);
      end
      assign tick = &cnt;
   end else begin : g_cmp
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      always_ff @(posedge clk) begin
         if (rst)              cnt <= '0;
         else if (cnt == LAST) cnt <= '0;
         else                  cnt <= cnt + CW'(1);
      end
      assign tick = (cnt == LAST);
   end

   p_tick_gap_r2: assert property (@(posedge clk) disable iff (rst)
      tick |=> !tick)
      else $error("p_tick_gap_r2");
endmodule

// File: rtl/rtc_commit_timer.sv
module rtc_commit_timer #(
   parameter int LAT = 3
) (
   input  logic clk,
   input  logic rst,
   input  logic accept,
   output logic ready
);
   localparam int CW = $clog2(LAT + 1);

   if (LAT < 1) begin : g_bad_lat
      $error("rtc_commit_timer: LAT must be at least 1");
   end

   logic [CW-1:0] busy;

   always_ff @(posedge clk) begin
      if (rst)               busy <= '0;
      else if (accept)       busy <= CW'(LAT);
      else if (busy != '0)   busy <= busy - CW'(1);
   end

   assign ready = (busy == '0);

   p_busy_after_accept_r3: assert property (@(posedge clk) disable iff (rst)
      accept |=> !ready)
      else $error("p_busy_after_accept_r3");

   p_busy_counts_down_r3: assert property (@(posedge clk) disable iff (rst)
      (!ready && !accept) |=> (busy == $past(busy) - CW'(1)))
      else $error("p_busy_counts_down_r3");
endmodule

// File: rtl/rtc_seconds_alarm.sv
module rtc_seconds_alarm
   import rtc_sec_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 4,
   parameter int TICK_DIV   = 32768,
   parameter int COMMIT_CYC = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_we,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);
   localparam logic [ADDR_W-1:0] A_SECS    = ADDR_W'(OFS_SECS);
   localparam logic [ADDR_W-1:0] A_ALARM   = ADDR_W'(OFS_ALARM);
   localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_SCRATCH = ADDR_W'(OFS_SCRATCH);

   if (DATA_W < CB_COUNT) begin : g_bad_dw
      $error("rtc_seconds_alarm: DATA_W too narrow for control bits");
   end
   if (ADDR_W < 4) begin : g_bad_aw
      $error("rtc_seconds_alarm: ADDR_W must reach offset 0xC");
   end

   logic              tick, wr_ready, accept;
   logic              w_secs, w_alarm, w_ctrl, w_scr;
   logic              inc, alarm_hit;
   logic [DATA_W-1:0] secs, secs_next, alarm, scratch, ctrl_view;
   logic              alarm_en, tick_ie, apend, tflag;
   reg_sel_e          sel;

   rtc_tick_gen #(.DIV(TICK_DIV)) u_tick (
      .clk  (clk),
      .rst  (rst),
      .tick (tick)
   );

   rtc_commit_timer #(.LAT(COMMIT_CYC)) u_commit (
      .clk    (clk),
      .rst    (rst),
      .accept (accept),
      .ready  (wr_ready)
   );

   always_comb begin
      case (bus_addr)
         A_SECS:    sel = SEL_SECS;
         A_ALARM:   sel = SEL_ALARM;
         A_CTRL:    sel = SEL_CTRL;
         A_SCRATCH: sel = SEL_SCRATCH;
         default:   sel = SEL_NONE;
      endcase
   end

   assign accept    = bus_we & wr_ready;
   assign w_secs    = accept & (sel == SEL_SECS);
   assign w_alarm   = accept & (sel == SEL_ALARM);
   assign w_ctrl    = accept & (sel == SEL_CTRL);
   assign w_scr     = accept & (sel == SEL_SCRATCH);
   assign secs_next = secs + DATA_W'(1);
   assign inc       = tick & ~w_secs;
   assign alarm_hit = inc & alarm_en & (secs_next == alarm);

   always_ff @(posedge clk) begin
      if (rst) begin
         secs     <= '0;
         alarm    <= '0;
         scratch  <= '0;
         alarm_en <= 1'b0;
         tick_ie  <= 1'b0;
         apend    <= 1'b0;
         tflag    <= 1'b0;
      end else begin
         if (w_secs)     secs <= bus_wdata;
         else if (inc)   secs <= secs_next;
         if (w_alarm)    alarm   <= bus_wdata;
         if (w_scr)      scratch <= bus_wdata;
         if (w_ctrl) begin
            alarm_en <= bus_wdata[CB_AEN];
            tick_ie  <= bus_wdata[CB_TIE];
            apend    <= (apend & bus_wdata[CB_APEND]) | alarm_hit;
            tflag    <= (tflag & bus_wdata[CB_TFLAG]) | inc;
         end else begin
            apend    <= apend | alarm_hit;
            tflag    <= tflag | inc;
         end
      end
   end

   always_comb begin
      ctrl_view           = '0;
      ctrl_view[CB_AEN]   = alarm_en;
      ctrl_view[CB_APEND] = apend;
      ctrl_view[CB_TFLAG] = tflag;
      ctrl_view[CB_WRDY]  = wr_ready;
      ctrl_view[CB_TIE]   = tick_ie;
   end

   always_comb begin
      case (sel)
         SEL_SECS:    bus_rdata = secs;
         SEL_ALARM:   bus_rdata = alarm;
         SEL_CTRL:    bus_rdata = ctrl_view;
         SEL_SCRATCH: bus_rdata = scratch;
         default:     bus_rdata = '0;
      endcase
   end

   assign irq = apend | (tflag & tick_ie);

   p_secs_step_r2: assert property (@(posedge clk) disable iff (rst)
      inc |=> (secs == $past(secs) + DATA_W'(1)))
      else $error("p_secs_step_r2");

   p_secs_hold_r2: assert property (@(posedge clk) disable iff (rst)
      (!tick && !w_secs) |=> $stable(secs))
      else $error("p_secs_hold_r2");

   p_ignore_busy_r3: assert property (@(posedge clk) disable iff (rst)
      (bus_we && !wr_ready) |=> ($stable(scratch) && $stable(alarm)))
      else $error("p_ignore_busy_r3");

   p_pend_needs_en_r4: assert property (@(posedge clk) disable iff (rst)
      $rose(apend) |-> $past(alarm_en))
      else $error("p_pend_needs_en_r4");

   p_flag_keep_r5: assert property (@(posedge clk) disable iff (rst)
      (tflag && !(w_ctrl && !bus_wdata[CB_TFLAG])) |=> tflag)
      else $error("p_flag_keep_r5");

   p_irq_source_r6: assert property (@(posedge clk) disable iff (rst)
      irq |-> (apend || tflag))
      else $error("p_irq_source_r6");

   p_secs_write_r10: assert property (@(posedge clk) disable iff (rst)
      w_secs |=> (secs == $past(bus_wdata)))
      else $error("p_secs_write_r10");
endmodule

// File: tb/sim_rtc_seconds_alarm.sv
`timescale 1ns/1ps
module sim_rtc_seconds_alarm;
   localparam int DIV = 8;
   localparam int LAT = 3;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_rdata;
   logic        irq;

   int checks = 0;
   int errors = 0;

   // reference model state
   int          m_pre;
   int          m_busy;
   logic [31:0] m_secs, m_alarm, m_scr;
   bit          m_ae, m_tie, m_pend, m_tf;
   logic [31:0] last_rd, last_exp;

   always #2.5 clk = ~clk;

   rtc_seconds_alarm #(
      .DATA_W(32), .ADDR_W(4), .TICK_DIV(DIV), .COMMIT_CYC(LAT)
   ) u0 (
      .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_rdata(bus_rdata), .irq(irq)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] m_read(logic [3:0] a);
      case (a)
         4'h0: return m_secs;
         4'h4: return m_alarm;
         4'h8: return {27'd0, m_tie, (m_busy == 0), m_tf, m_pend, m_ae};
         4'hC: return m_scr;
         default: return 32'd0;
      endcase
   endfunction

   task automatic m_reset();
      m_pre = 0; m_busy = 0;
      m_secs = 0; m_alarm = 0; m_scr = 0;
      m_ae = 0; m_tie = 0; m_pend = 0; m_tf = 0;
   endtask

   task automatic m_step(bit we, logic [3:0] a, logic [31:0] d);
      bit tick, acc, ws, step, hit;
      tick = (m_pre == DIV - 1);
      m_pre = tick ? 0 : m_pre + 1;
      acc = we && (m_busy == 0);
      ws = acc && (a == 4'h0);
      step = tick && !ws;
      hit = step && m_ae && (m_secs + 32'd1 == m_alarm);
      if (acc && a == 4'h8) begin
         m_pend = (m_pend && d[1]) || hit;
         m_tf = (m_tf && d[2]) || step;
         m_ae = d[0];
         m_tie = d[4];
      end else begin
         m_pend = m_pend || hit;
         m_tf = m_tf || step;
      end
      if (ws) m_secs = d;
      else if (step) m_secs = m_secs + 32'd1;
      if (acc && a == 4'h4) m_alarm = d;
      if (acc && a == 4'hC) m_scr = d;
      if (acc) m_busy = LAT;
      else if (m_busy > 0) m_busy = m_busy - 1;
   endtask

   // one bus cycle: drive, compare, advance model at the edge
   task automatic cyc(bit we, logic [3:0] a, logic [31:0] d, string tag);
      bus_we = we; bus_addr = a; bus_wdata = d;
      #1;
      last_rd = bus_rdata;
      last_exp = m_read(a);
      chk(tag, bus_rdata, last_exp);
      chk("R6", {31'd0, irq}, {31'd0, m_pend || (m_tf && m_tie)});
      @(posedge clk);
      m_step(we, a, d);
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic idle(int n, logic [3:0] a, string tag);
      for (int i = 0; i < n; i++) cyc(0, a, 32'd0, tag);
   endtask

   initial begin
      #1000000;
      errors++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      m_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;

      // R1 reset state
      cyc(0, 4'h0, 0, "R1");
      cyc(0, 4'h4, 0, "R1");
      cyc(0, 4'h8, 0, "R1");
      cyc(0, 4'hC, 0, "R1");

      // R7 scratch marker, R3 commit window
      cyc(1, 4'hC, 32'h12345678, "R7");
      idle(LAT + 1, 4'h8, "R3");
      cyc(0, 4'hC, 0, "R7");

      // R3 write dropped while busy
      cyc(1, 4'hC, 32'hA5A5_0001, "R3");
      cyc(1, 4'hC, 32'h5A5A_0002, "R3");
      cyc(1, 4'h4, 32'h0000_0077, "R3");
      cyc(0, 4'h8, 0, "R3");
      idle(LAT, 4'hC, "R3");
      cyc(0, 4'h4, 0, "R3");

      // R8 unmapped offsets
      cyc(0, 4'h2, 0, "R8");
      cyc(0, 4'h5, 0, "R8");
      cyc(0, 4'hF, 0, "R8");

      // R2 counting and tick flag
      idle(3 * DIV, 4'h0, "R2");
      idle(DIV, 4'h8, "R2");

      // R5 write ones keeps flags, write zero clears
      cyc(1, 4'h8, 32'h6, "R5");
      idle(LAT, 4'h8, "R5");
      cyc(1, 4'h8, 32'h0, "R5");
      idle(LAT + 2, 4'h8, "R5");

      // R6 tick interrupt enable
      cyc(1, 4'h8, 32'h10, "R6");
      idle(DIV + 2, 4'h8, "R6");
      cyc(1, 4'h8, 32'h10, "R6");
      idle(LAT, 4'h8, "R6");

      // R10 seconds write at every prescaler phase
      for (int p = 0; p < DIV; p++) begin
         cyc(1, 4'h0, 32'd100 + p, "R10");
         idle(LAT, 4'h0, "R10");
         idle(1, 4'h8, "R10");
      end

      // R4 alarm armed: two steps ahead
      cyc(1, 4'h4, m_secs + 32'd2, "R4");
      idle(LAT, 4'h4, "R4");
      cyc(1, 4'h8, 32'h1, "R4");
      idle(3 * DIV, 4'h8, "R4");
      chk("R4", {31'd0, irq}, 32'd1);
      cyc(1, 4'h8, 32'h5, "R5");
      idle(LAT, 4'h8, "R5");
      cyc(1, 4'h8, 32'h0, "R5");
      idle(LAT, 4'h8, "R5");

      // R4 alarm disarmed: no pending
      cyc(1, 4'h4, m_secs + 32'd1, "R4");
      idle(LAT, 4'h8, "R4");
      idle(2 * DIV, 4'h8, "R4");

      // R9 double read across step boundaries
      for (int k = 0; k < 3 * DIV; k++) begin
         logic [31:0] v1;
         cyc(0, 4'h0, 0, "R9");
         v1 = last_rd;
         cyc(0, 4'h0, 0, "R9");
         if (v1 == last_rd) chk("R9", last_rd, last_exp);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule